// File: doc/BRIEF.md
# Register-Shifted XOR Flag-Test Unit

This execute-stage block handles one compare-style operation of a 32-bit instruction set. The second operand is shifted by an amount held in a third register, and the result is combined with the first operand by exclusive OR. The XOR value is used only to produce new condition flags and is never written back. Each cycle, the block decodes the instruction word presented with `issue_i` against a fixed opcode pattern. It picks out the three register indices and the shift kind, shifts the second operand, and registers the resulting NZCV flags. Register-file reads, fetch and general condition evaluation happen elsewhere. The block takes the already-read operand values and a condition-passed input.

Shift amounts come from the low byte of a register, so they range from 0 to 255. Amounts of the data width or more follow exact carry rules for each shift kind. Encodings that name register index 15 in any of the three index fields are reported on a separate output.

Top module: `xorshift_test_unit`

## Requirements
- R1: An instruction hits when bits 27..20 equal 8'h13, bit 7 is 0, bit 4 is 1 and bits 31..28 are not 4'hF. Bits 15..12 do not affect the hit.
- R2: A result appears one clock edge after `issue_i`. `done_o` is 1 exactly in the cycle after an issue cycle. All other outputs hold their values when `issue_i` is 0, and the latency never depends on data or flag values.
- R3: For a hit, `unpred_o` is 1 when any of the index fields at bits 19..16, 11..8 or 3..0 equals 15. It is 0 otherwise.
- R4: The shift amount is the unsigned value of bits 7..0 of `amt_reg_i`. Bits 31..8 have no effect.
- R5: On an update, N (`flags_o[3]`) is bit 31 of `opnd_a_i` XOR the shifted operand, and Z (`flags_o[2]`) is 1 when that value is zero.
- R6: On an update, C (`flags_o[1]`) is the shifter carry-out. V (`flags_o[0]`) always equals the incoming `flags_i[0]`.
- R7: When the instruction does not hit or `cond_pass_i` is 0, `flags_o` becomes `flags_i` unchanged.
- R8: The shift kind is taken from bits 6..5: 00 logical left, 01 logical right, 10 arithmetic right, 11 rotate right. An amount of 0 leaves the operand unchanged and gives carry equal to `flags_i[1]`.
- R9: For logical shifts by 1 to 31 the carry is the last bit shifted out. An amount of exactly 32 gives a zero result, with carry equal to bit 0 for a left shift and bit 31 for a right shift. Amounts above 32 give zero result and zero carry.
- R10: An arithmetic right shift by 32 or more fills every bit with bit 31 and sets carry to bit 31.
- R11: A rotate uses the amount modulo 32, and its carry is bit 31 of the rotated value. A nonzero multiple of 32 leaves the operand unchanged and gives carry equal to bit 31.
- R12: While reset is applied, and until the first issue after it, `done_o`, `hit_o`, `unpred_o` and `flags_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_i | input | 1 | Operation presented this cycle |
| instr_i | input | 32 | Instruction word |
| opnd_a_i | input | 32 | First operand value |
| opnd_b_i | input | 32 | Operand value to be shifted |
| amt_reg_i | input | 32 | Register holding the shift amount in its low byte |
| flags_i | input | 4 | Current NZCV flags, N in bit 3 |
| cond_pass_i | input | 1 | Condition check passed |
| done_o | output | 1 | Result registered from the previous cycle |
| hit_o | output | 1 | Registered opcode hit |
| unpred_o | output | 1 | Registered reserved-index report |
| flags_o | output | 4 | Registered NZCV flags, N in bit 3 |

## Verification
The assertions assume that every input is a known value on every cycle in which `issue_i` is 1. They also assume `rst_n` stays low for at least two clock edges, so the synchronized reset reaches the registers. The stimulus respects both conditions. It drives all inputs on the falling edge and holds reset for several cycles before the first issue. It also ensures that any changes to `flags_i` or the operands while `issue_i` is 0 are irrelevant to the outputs. This lets the hold property be exercised with random data on idle cycles.

// File: rtl/xst_pkg.sv
package xst_pkg;

  typedef enum logic [1:0] {
    SH_LSL = 2'b00,
    SH_LSR = 2'b01,
    SH_ASR = 2'b10,
    SH_ROR = 2'b11
  } shift_kind_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;

  localparam int          INSTR_W   = 32;
  localparam int          IDX_W     = 4;
  localparam int          NUM_IDX   = 3;
  localparam logic [7:0]  OPC_MAJOR = 8'h13;
  localparam logic [3:0]  COND_NV   = 4'hF;
  localparam logic [3:0]  IDX_RSVD  = 4'hF;

endpackage

// File: rtl/xst_decode.sv
module xst_decode
  import xst_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  output logic               hit_o,
  output shift_kind_e        kind_o,
  output logic               rsvd_idx_o
);

  localparam int IDX_LSB [NUM_IDX] = '{16, 8, 0};

  logic [NUM_IDX-1:0] idx_is_rsvd;
  logic [3:0]         unused_sbz;

  generate
    for (genvar g = 0; g < NUM_IDX; g++) begin : g_idx
      assign idx_is_rsvd[g] = (instr_i[IDX_LSB[g] +: IDX_W] == IDX_RSVD);
    end
  endgenerate

  always_comb begin
    hit_o = (instr_i[27:20] == OPC_MAJOR) && !instr_i[7] && instr_i[4] &&
            (instr_i[31:28] != COND_NV);
    kind_o     = shift_kind_e'(instr_i[6:5]);
    rsvd_idx_o = |idx_is_rsvd;
  end

  assign unused_sbz = instr_i[15:12];

endmodule

// File: rtl/xst_shifter.sv
module xst_shifter
  import xst_pkg::*;
#(
  parameter int DW    = 32,
  parameter int AMT_W = 8
) (
  input  logic [DW-1:0]    opnd_i,
  input  logic [AMT_W-1:0] amt_i,
  input  shift_kind_e      kind_i,
  input  logic             cin_i,
  output logic [DW-1:0]    res_o,
  output logic             cout_o
);

  localparam int IW = $clog2(DW);

  logic [IW-1:0]   lo;
  logic            amt_zero;
  logic            amt_below;
  logic            amt_at_w;
  logic            amt_past_w;
  logic [2*DW-1:0] dbl;

  always_comb begin
    lo         = amt_i[IW-1:0];
    amt_zero   = (amt_i == '0);
    amt_below  = !amt_zero && (int'(amt_i) < DW);
    amt_at_w   = (int'(amt_i) == DW);
    amt_past_w = (int'(amt_i) > DW);
    dbl        = '0;
    res_o      = opnd_i;
    cout_o     = cin_i;
    unique case (kind_i)
      SH_LSL: begin
        if (amt_below) begin
          res_o  = opnd_i << lo;
          cout_o = opnd_i[IW'(0) - lo];
        end else if (amt_at_w) begin
          res_o  = '0;
          cout_o = opnd_i[0];
        end else if (amt_past_w) begin
          res_o  = '0;
          cout_o = 1'b0;
        end
      end
      SH_LSR: begin
        if (amt_below) begin
          res_o  = opnd_i >> lo;
          cout_o = opnd_i[lo - IW'(1)];
        end else if (amt_at_w) begin
          res_o  = '0;
          cout_o = opnd_i[DW-1];
        end else if (amt_past_w) begin
          res_o  = '0;
          cout_o = 1'b0;
        end
      end
      SH_ASR: begin
        if (amt_below) begin
          res_o  = $signed(opnd_i) >>> lo;
          cout_o = opnd_i[lo - IW'(1)];
        end else if (!amt_zero) begin
          res_o  = {DW{opnd_i[DW-1]}};
          cout_o = opnd_i[DW-1];
        end
      end
      default: begin
        if (!amt_zero) begin
          dbl    = {opnd_i, opnd_i} >> lo;
          res_o  = dbl[DW-1:0];
          cout_o = dbl[DW-1];
        end
      end
    endcase
  end

endmodule

// File: rtl/xst_flags.sv
module xst_flags
  import xst_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0] opnd_a_i,
  input  logic [DW-1:0] shifted_i,
  input  logic          sh_carry_i,
  input  nzcv_t         flags_i,
  input  logic          apply_i,
  output nzcv_t         flags_o
);

  logic [DW-1:0] eor;

  always_comb begin
    eor     = opnd_a_i ^ shifted_i;
    flags_o = flags_i;
    if (apply_i) begin
      flags_o.n = eor[DW-1];
      flags_o.z = (eor == '0);
      flags_o.c = sh_carry_i;
    end
  end

endmodule

// File: rtl/xorshift_test_unit.sv
module xorshift_test_unit
  import xst_pkg::*;
#(
  parameter int DW    = 32,
  parameter int AMT_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               issue_i,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic [DW-1:0]      opnd_a_i,
  input  logic [DW-1:0]      opnd_b_i,
  input  logic [DW-1:0]      amt_reg_i,
  input  logic [3:0]         flags_i,
  input  logic               cond_pass_i,
  output logic               done_o,
  output logic               hit_o,
  output logic               unpred_o,
  output logic [3:0]         flags_o
);

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              dec_hit;
  logic              dec_rsvd;
  shift_kind_e       dec_kind;
  logic [DW-1:0]     sh_res;
  logic              sh_cout;
  logic              upd_en;
  nzcv_t             flags_in_s;
  nzcv_t             flags_nxt;
  logic              done_d, hit_d, unpred_d;
  logic [3:0]        flags_d;
  logic [DW-AMT_W-1:0] unused_amt_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  xst_decode u_dec (
    .instr_i    (instr_i),
    .hit_o      (dec_hit),
    .kind_o     (dec_kind),
    .rsvd_idx_o (dec_rsvd)
  );

  xst_shifter #(.DW(DW), .AMT_W(AMT_W)) u_shf (
    .opnd_i (opnd_b_i),
    .amt_i  (amt_reg_i[AMT_W-1:0]),
    .kind_i (dec_kind),
    .cin_i  (flags_i[1]),
    .res_o  (sh_res),
    .cout_o (sh_cout)
  );

  assign unused_amt_hi = amt_reg_i[DW-1:AMT_W];
  assign flags_in_s    = nzcv_t'(flags_i);
  assign upd_en        = dec_hit && cond_pass_i;

  xst_flags #(.DW(DW)) u_flg (
    .opnd_a_i   (opnd_a_i),
    .shifted_i  (sh_res),
    .sh_carry_i (sh_cout),
    .flags_i    (flags_in_s),
    .apply_i    (upd_en),
    .flags_o    (flags_nxt)
  );

  always_comb begin
    done_d   = issue_i;
    hit_d    = dec_hit;
    unpred_d = dec_hit && dec_rsvd;
    flags_d  = flags_nxt;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      done_o   <= 1'b0;
      hit_o    <= 1'b0;
      unpred_o <= 1'b0;
      flags_o  <= 4'h0;
    end else begin
      done_o <= done_d;
      if (issue_i) begin
        hit_o    <= hit_d;
        unpred_o <= unpred_d;
        flags_o  <= flags_d;
      end
    end
  end

  AST_DONE_AFTER_ISSUE: assert property (@(posedge clk) disable iff (!rst_int_n)
    issue_i |=> done_o);  // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_int_n)
    !issue_i |=> (!done_o && $stable(flags_o) && $stable(hit_o) && $stable(unpred_o)));  // R2
  AST_V_KEPT: assert property (@(posedge clk) disable iff (!rst_int_n)
    issue_i |=> (flags_o[0] == $past(flags_i[0])));  // R6
  AST_NO_UPDATE_PASS: assert property (@(posedge clk) disable iff (!rst_int_n)
    (issue_i && !upd_en) |=> (flags_o == $past(flags_i)));  // R7
  AST_UNPRED_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_int_n)
    unpred_o |-> hit_o);  // R3
  AST_ZERO_NOT_NEG: assert property (@(posedge clk) disable iff (!rst_int_n)
    (issue_i && upd_en) |=> !(flags_o[3] && flags_o[2]));  // R5

endmodule

// File: tb/xorshift_test_unit_tb_top.sv
`timescale 1ns/1ps
module xorshift_test_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        issue;
  logic [31:0] instr, opa, opb, amt;
  logic [3:0]  flg;
  logic        cpass;
  logic        done, hit, unpred;
  logic [3:0]  flg_out;
  int          n_chk = 0;
  int          n_fail = 0;

  always #2.5 clk = ~clk;

  xorshift_test_unit dut_i (
    .clk(clk), .rst_n(rst_n), .issue_i(issue), .instr_i(instr),
    .opnd_a_i(opa), .opnd_b_i(opb), .amt_reg_i(amt), .flags_i(flg),
    .cond_pass_i(cpass), .done_o(done), .hit_o(hit), .unpred_o(unpred),
    .flags_o(flg_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // bit-serial reference shifter, returns {carry, result}
  function automatic logic [32:0] ref_shift(input logic [31:0] b, input logic [7:0] n,
                                            input logic [1:0] k, input logic cin);
    logic [31:0] r = b;
    logic        c = cin;
    for (int i = 0; i < int'(n); i++) begin
      case (k)
        2'b00: begin c = r[31]; r = r << 1; end
        2'b01: begin c = r[0];  r = r >> 1; end
        2'b10: begin c = r[0];  r = {r[31], r[31:1]}; end
        default: begin r = {r[0], r[31:1]}; c = r[31]; end
      endcase
    end
    return {c, r};
  endfunction

  function automatic logic [31:0] mk(input logic [3:0] cond, input logic [1:0] k,
                                     input logic [3:0] ra, input logic [3:0] rs,
                                     input logic [3:0] rb, input logic [3:0] sbz);
    return {cond, 8'h13, ra, sbz, rs, 1'b0, k, 1'b1, rb};
  endfunction

  task automatic run_op(input string req, input logic [31:0] ins, input logic [31:0] a,
                        input logic [31:0] b, input logic [31:0] s, input logic [3:0] f,
                        input logic cp);
    logic        e_hit, e_unp;
    logic [32:0] sh;
    logic [31:0] x;
    logic [3:0]  e_f;
    issue = 1'b1; instr = ins; opa = a; opb = b; amt = s; flg = f; cpass = cp;
    e_hit = (ins[27:20] == 8'h13) && !ins[7] && ins[4] && (ins[31:28] != 4'hF);
    e_unp = e_hit && (ins[19:16] == 4'hF || ins[11:8] == 4'hF || ins[3:0] == 4'hF);
    sh    = ref_shift(b, s[7:0], ins[6:5], f[1]);
    x     = a ^ sh[31:0];
    e_f   = (e_hit && cp) ? {x[31], (x == 32'h0), sh[32], f[0]} : f;
    @(negedge clk);
    chk("R2 done", {31'h0, done}, 32'h1);
    chk("R1 hit", {31'h0, hit}, {31'h0, e_hit});
    chk("R3 unpred", {31'h0, unpred}, {31'h0, e_unp});
    chk(req, {28'h0, flg_out}, {28'h0, e_f});
  endtask

  task automatic idle_check();
    logic [3:0] f0 = flg_out;
    logic       h0 = hit;
    issue = 1'b0; instr = $urandom; opa = $urandom; opb = $urandom;
    amt = $urandom; flg = 4'($urandom); cpass = 1'b1;
    @(negedge clk);
    chk("R2 idle done", {31'h0, done}, 32'h0);
    chk("R2 idle hold", {27'h0, h0, flg_out}, {27'h0, h0, f0});
  endtask

  initial begin
    #(100000 * 5);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    logic [7:0] amts [6] = '{8'd0, 8'd1, 8'd31, 8'd32, 8'd33, 8'd255};
    void'($urandom(32'h1234_5678));
    rst_n = 1'b0; issue = 1'b0; instr = '0; opa = '0; opb = '0; amt = '0;
    flg = 4'hF; cpass = 1'b1;
    repeat (3) @(negedge clk);
    chk("R12 reset", {28'h0, done, hit, unpred, 1'b0}, 32'h0);
    chk("R12 reset flags", {28'h0, flg_out}, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R12 after release", {28'h0, done, hit, unpred, flg_out[0]}, 32'h0);

    // corner amounts for each shift kind, upper amount bits random
    for (int k = 0; k < 4; k++) begin
      for (int j = 0; j < 6; j++) begin
        run_op(k == 0 ? "R9 lsl" : k == 1 ? "R9 lsr" : k == 2 ? "R10 asr" : "R11 ror",
               mk(4'h0, 2'(k), 4'h1, 4'h2, 4'h3, 4'h0), 32'h0F0F_1234,
               32'h8000_0001, {24'($urandom), amts[j]}, 4'b0010, 1'b1);
        run_op("R8 kinds", mk(4'hE, 2'(k), 4'h4, 4'h5, 4'h6, 4'h0), 32'h1357_9BDF,
               32'h7FFF_FFFE, {24'hABCDEF, amts[j]}, 4'b1101, 1'b1);
      end
    end
    run_op("R11 ror 64", mk(4'h0, 2'b11, 4'h1, 4'h2, 4'h3, 4'h0), 32'h0,
           32'h8000_0000, 32'd64, 4'b0000, 1'b1);
    run_op("R4 high bits", mk(4'h0, 2'b00, 4'h1, 4'h2, 4'h3, 4'h0), 32'h0,
           32'h0000_0001, 32'hFFFF_FF00, 4'b0010, 1'b1);
    run_op("R5 zero", mk(4'h0, 2'b01, 4'h1, 4'h2, 4'h3, 4'h0), 32'h0000_0F0F,
           32'h0000_F0F0, 32'd4, 4'b1000, 1'b1);
    run_op("R5 negative", mk(4'h0, 2'b00, 4'h1, 4'h2, 4'h3, 4'h0), 32'h8000_0000,
           32'h0, 32'd3, 4'b0101, 1'b1);
    run_op("R6 V kept", mk(4'h0, 2'b10, 4'h1, 4'h2, 4'h3, 4'h0), 32'h1,
           32'h8000_0000, 32'd40, 4'b0001, 1'b1);
    run_op("R7 cond fail", mk(4'h0, 2'b00, 4'h1, 4'h2, 4'h3, 4'h0), 32'h1,
           32'h2, 32'd1, 4'b1010, 1'b0);
    run_op("R1 cond NV", mk(4'hF, 2'b00, 4'h1, 4'h2, 4'h3, 4'h0), 32'h1,
           32'h2, 32'd1, 4'b0110, 1'b1);
    run_op("R1 bit7 set", mk(4'h0, 2'b00, 4'h1, 4'h2, 4'h3, 4'h0) | 32'h80, 32'h1,
           32'h2, 32'd1, 4'b0110, 1'b1);
    run_op("R1 bit4 clear", mk(4'h0, 2'b00, 4'h1, 4'h2, 4'h3, 4'h0) & ~32'h10, 32'h1,
           32'h2, 32'd1, 4'b0110, 1'b1);
    run_op("R1 sbz ignored", mk(4'h0, 2'b00, 4'h1, 4'h2, 4'h3, 4'hA), 32'h1,
           32'h2, 32'd1, 4'b0110, 1'b1);
    run_op("R3 ra15", mk(4'h0, 2'b00, 4'hF, 4'h2, 4'h3, 4'h0), 32'h5, 32'h5, 32'd0, 4'h0, 1'b1);
    run_op("R3 rs15", mk(4'h0, 2'b00, 4'h1, 4'hF, 4'h3, 4'h0), 32'h5, 32'h5, 32'd0, 4'h0, 1'b1);
    run_op("R3 rb15", mk(4'h0, 2'b00, 4'h1, 4'h2, 4'hF, 4'h0), 32'h5, 32'h5, 32'd0, 4'h0, 1'b1);
    idle_check();

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] ins = mk(4'($urandom % 15), 2'($urandom), 4'($urandom), 4'($urandom),
                            4'($urandom), 4'($urandom));
      logic [31:0] s = $urandom;
      if ($urandom % 8 == 0) ins = $urandom;
      if ($urandom % 2 == 0) s[7:0] = 8'($urandom % 34);
      run_op("R5 R6 random", ins, $urandom, $urandom, s, 4'($urandom), ($urandom % 6) != 0);
      if (i % 50 == 0) idle_check();
    end

    issue = 1'b0;
    @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule